// File: doc/BRIEF.md
# 8-bit Waveform Timer

An 8-bit counter with two output-compare channels. Each channel has its own compare register, a match flag and a waveform pin. A mode field picks how the counter runs. In free-running mode it wraps at the all-ones value. In clear-on-match mode it returns to zero after reaching compare register A. The two single-slope PWM modes differ only in TOP, which is either all-ones or compare register A. Counting advances only in cycles where the `tick` enable is high, so an external prescaler sets the count rate.

Software-style register writes arrive as single-cycle strobes. These strobes load the counter, either compare register, or the control fields (mode and the two per-channel output actions). Per-channel force strobes apply a channel's output action at once without waiting for a match. A clear strobe vector clears the flags by writing ones. Loading the counter masks compare matches on the next tick, so a freshly written count does not trigger a spurious match.

Top module: `wavegen_timer`

## Requirements
- R1: After reset, `count`, both compare registers, both waveform pins, `ovf_flag` and `match_flag` are zero, and the mode is 0.
- R2: In mode 0, any mode value other than 2, 3 or 7, each tick adds one to `count` and wraps 0xFF to 0x00. `ovf_flag` sets at the edge of that wrapping tick. `count` holds in cycles without a tick or a counter write.
- R3: In mode 2, a tick with `count` equal to compare register A sends `count` to 0. With action 1 and register A at 0, channel A's pin toggles on every tick, so its period is two ticks.
- R4: Mode 3 is PWM with TOP = 0xFF. Mode 7 is PWM with TOP = compare register A. In both PWM modes, a tick at TOP sends `count` to 0 and sets `ovf_flag`.
- R5: In PWM modes, action 2 clears the pin on a compare-match tick and sets it on the tick that wraps TOP to 0. Action 3 does the opposite. When both events fall on one tick, the wrap action wins. Actions 0 and 1 leave the pin unchanged.
- R6: In non-PWM modes, a compare-match event applies the channel's action. Action 1 toggles the pin, action 2 clears it and action 3 sets it. Action 0 leaves the pin holding its last value.
- R7: A channel's match flag sets at the edge of a tick in which `count` equals that channel's compare register, unless the match is masked.
- R8: In non-PWM modes, a force strobe applies the channel's action at the next clock edge, with or without a tick. It sets no flag and does not change `count`. In PWM modes it has no effect. A force that coincides with a real match applies the action only once.
- R9: `cnt_wr` loads `cnt_wdata` into `count`, taking priority over a tick in the same cycle. On the next tick after the load, no compare match is detected.
- R10: A one in `flag_clr` clears a flag: bit 0 clears `ovf_flag`, bit 1 clears channel A's flag and bit 2 clears channel B's flag. A flag that sets in the same cycle stays set.
- R11: Control strobes write `ctl_mode` and `ctl_act`, where bits [1:0] are channel A's action and bits [3:2] are channel B's. `ocr_wr[i]` loads `ocr_wdata` into channel i's compare register. New values take effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | W | Counter load value |
| ocr_wr | input | NCH | Per-channel compare register write strobes |
| ocr_wdata | input | W | Compare register write value |
| ctl_wr | input | 1 | Control write strobe |
| ctl_mode | input | 3 | Counting mode |
| ctl_act | input | 2*NCH | Per-channel output action, 2 bits each |
| force_cmp | input | NCH | Per-channel force strobes |
| flag_clr | input | NCH+1 | Write-one-to-clear for the overflow flag (bit 0) and the match flags |
| count | output | W | Counter value |
| wave | output | NCH | Waveform pins |
| ovf_flag | output | 1 | Overflow / TOP flag |
| match_flag | output | NCH | Compare-match flags |

## Verification
Two pairs of events can fall on the same tick, and the bench checks how each pair resolves.

- **Match at TOP in PWM.** When a compare register equals TOP in a PWM mode, the channel's match and the wrap to BOTTOM happen on the same tick. The bench forces this by sweeping compare values that include TOP, and in mode 7 by giving both channels the register A value. The pin must take the wrap action.
- **Force during a real match.** In non-PWM modes the bench issues random force strobes while matches are occurring. A toggle action must flip the pin exactly once, and no flag may set from the force alone.

Each case is judged cycle by cycle against an arithmetic model of the requirements.

// File: rtl/wgt_pkg.sv
package wgt_pkg;
  localparam int MODE_W = 3;
  localparam int ACT_W  = 2;

  localparam logic [MODE_W-1:0] MD_FREE    = 3'd0;
  localparam logic [MODE_W-1:0] MD_CLRMAT  = 3'd2;
  localparam logic [MODE_W-1:0] MD_PWM_MAX = 3'd3;
  localparam logic [MODE_W-1:0] MD_PWM_REG = 3'd7;

  localparam logic [ACT_W-1:0] ACT_OFF = 2'd0;
  localparam logic [ACT_W-1:0] ACT_TGL = 2'd1;
  localparam logic [ACT_W-1:0] ACT_CLR = 2'd2;
  localparam logic [ACT_W-1:0] ACT_SET = 2'd3;

  function automatic logic mode_is_pwm(input logic [MODE_W-1:0] m);
    return (m == MD_PWM_MAX) || (m == MD_PWM_REG);
  endfunction

  function automatic logic mode_top_is_reg(input logic [MODE_W-1:0] m);
    return (m == MD_CLRMAT) || (m == MD_PWM_REG);
  endfunction

  function automatic logic mode_has_top(input logic [MODE_W-1:0] m);
    return (m == MD_CLRMAT) || mode_is_pwm(m);
  endfunction
endpackage

// File: rtl/wgt_counter.sv
module wgt_counter
  import wgt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [W-1:0]      load_val,
  input  logic [MODE_W-1:0] mode,
  input  logic [W-1:0]      reg_top,
  output logic [W-1:0]      cnt,
  output logic              blk,
  output logic              ovf_ev,
  output logic              bottom_ev
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] top;
  logic         at_top;
  logic         pwm;
  logic [W-1:0] cnt_d;
  logic         blk_d;

  always_comb begin
    pwm       = mode_is_pwm(mode);
    top       = mode_top_is_reg(mode) ? reg_top : MAXV;
    at_top    = (cnt == top);
    ovf_ev    = tick && (pwm ? at_top : (cnt == MAXV));
    bottom_ev = tick && pwm && at_top;
    if (load)
      cnt_d = load_val;
    else if (tick)
      cnt_d = (mode_has_top(mode) && at_top) ? '0 : cnt + ONE;
    else
      cnt_d = cnt;
    if (load)
      blk_d = 1'b1;
    else if (tick)
      blk_d = 1'b0;
    else
      blk_d = blk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else begin
      cnt <= cnt_d;
      blk <= blk_d;
    end
  end
endmodule

// File: rtl/wgt_channel.sv
module wgt_channel
  import wgt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             blk,
  input  logic [W-1:0]     cnt,
  input  logic             ocr_wr,
  input  logic [W-1:0]     ocr_wdata,
  input  logic [ACT_W-1:0] act,
  input  logic             pwm,
  input  logic             force_s,
  input  logic             bottom_ev,
  input  logic             clr,
  output logic [W-1:0]     ocr,
  output logic             wave,
  output logic             mflag
);
  logic         hit;
  logic         wave_d;
  logic         mflag_d;
  logic [W-1:0] ocr_d;

  always_comb begin
    hit    = tick && !blk && (cnt == ocr);
    wave_d = wave;
    if (pwm) begin
      if (hit) begin
        if (act == ACT_CLR) wave_d = 1'b0;
        if (act == ACT_SET) wave_d = 1'b1;
      end
      if (bottom_ev) begin
        if (act == ACT_CLR) wave_d = 1'b1;
        if (act == ACT_SET) wave_d = 1'b0;
      end
    end else if (hit || force_s) begin
      case (act)
        ACT_TGL: wave_d = ~wave;
        ACT_CLR: wave_d = 1'b0;
        ACT_SET: wave_d = 1'b1;
        default: wave_d = wave;
      endcase
    end
    mflag_d = hit | (mflag & ~clr);
    ocr_d   = ocr_wr ? ocr_wdata : ocr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocr   <= '0;
      wave  <= 1'b0;
      mflag <= 1'b0;
    end else begin
      ocr   <= ocr_d;
      wave  <= wave_d;
      mflag <= mflag_d;
    end
  end
endmodule

// File: rtl/wavegen_timer.sv
module wavegen_timer
  import wgt_pkg::*;
#(
  parameter int W   = 8,
  parameter int NCH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 cnt_wr,
  input  logic [W-1:0]         cnt_wdata,
  input  logic [NCH-1:0]       ocr_wr,
  input  logic [W-1:0]         ocr_wdata,
  input  logic                 ctl_wr,
  input  logic [MODE_W-1:0]    ctl_mode,
  input  logic [ACT_W*NCH-1:0] ctl_act,
  input  logic [NCH-1:0]       force_cmp,
  input  logic [NCH:0]         flag_clr,
  output logic [W-1:0]         count,
  output logic [NCH-1:0]       wave,
  output logic                 ovf_flag,
  output logic [NCH-1:0]       match_flag
);
  logic [MODE_W-1:0]    mode_q, mode_d;
  logic [ACT_W*NCH-1:0] act_q, act_d;
  logic                 ovf_d;
  logic                 pwm;
  logic                 blk;
  logic                 ovf_ev;
  logic                 bottom_ev;
  logic [W-1:0]         ocr_v [NCH];

  always_comb begin
    pwm    = mode_is_pwm(mode_q);
    mode_d = ctl_wr ? ctl_mode : mode_q;
    act_d  = ctl_wr ? ctl_act : act_q;
    ovf_d  = ovf_ev | (ovf_flag & ~flag_clr[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_FREE;
      act_q    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      act_q    <= act_d;
      ovf_flag <= ovf_d;
    end
  end

  wgt_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (cnt_wr),
    .load_val  (cnt_wdata),
    .mode      (mode_q),
    .reg_top   (ocr_v[0]),
    .cnt       (count),
    .blk       (blk),
    .ovf_ev    (ovf_ev),
    .bottom_ev (bottom_ev)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wgt_channel #(.W(W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .blk       (blk),
      .cnt       (count),
      .ocr_wr    (ocr_wr[i]),
      .ocr_wdata (ocr_wdata),
      .act       (act_q[ACT_W*i +: ACT_W]),
      .pwm       (pwm),
      .force_s   (force_cmp[i]),
      .bottom_ev (bottom_ev),
      .clr       (flag_clr[i+1]),
      .ocr       (ocr_v[i]),
      .wave      (wave[i]),
      .mflag     (match_flag[i])
    );
  end
endmodule

// File: rtl/wgt_chk.sv
module wgt_chk
  import wgt_pkg::*;
#(
  parameter int W   = 8,
  parameter int NCH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              cnt_wr,
  input logic [W-1:0]      cnt_wdata,
  input logic [NCH:0]      flag_clr,
  input logic [W-1:0]      count,
  input logic [NCH-1:0]    wave,
  input logic              ovf_flag,
  input logic [NCH-1:0]    match_flag,
  input logic [MODE_W-1:0] mode_q
);
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(count));

  // R9
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count == $past(cnt_wdata)));

  // R9
  match_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(cnt_wr)) |=>
      (match_flag == ($past(match_flag) & ~$past(flag_clr[NCH:1]))));

  // R7
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((match_flag & ~$past(match_flag)) == '0));

  // R2
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !$rose(ovf_flag));

  // R8
  pwm_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_pwm(mode_q) && !tick) |=> $stable(wave));
endmodule

bind wavegen_timer wgt_chk #(.W(W), .NCH(NCH)) u_chk (.*);

// File: tb/sim_wavegen_timer.sv
module sim_wavegen_timer;
  localparam int  W    = 8;
  localparam int  NCH  = 2;
  localparam time TCLK = 10;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           tick;
  logic           cnt_wr;
  logic [W-1:0]   cnt_wdata;
  logic [NCH-1:0] ocr_wr;
  logic [W-1:0]   ocr_wdata;
  logic           ctl_wr;
  logic [2:0]     ctl_mode;
  logic [3:0]     ctl_act;
  logic [NCH-1:0] force_cmp;
  logic [NCH:0]   flag_clr;
  logic [W-1:0]   count;
  logic [NCH-1:0] wave;
  logic           ovf_flag;
  logic [NCH-1:0] match_flag;

  wavegen_timer #(.W(W), .NCH(NCH)) u0 (.*);

  always #(TCLK/2) clk = ~clk;

  int vec = 0;
  int bad = 0;

  logic [W-1:0]   m_cnt;
  logic [W-1:0]   m_ocr [NCH];
  logic [2:0]     m_mode;
  logic [1:0]     m_act [NCH];
  logic [NCH-1:0] m_wave;
  logic [NCH-1:0] m_mf;
  logic           m_ovf;
  logic           m_blk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_mode = 3'd0; m_wave = '0; m_mf = '0; m_ovf = 1'b0; m_blk = 1'b0;
    for (int i = 0; i < NCH; i++) begin m_ocr[i] = '0; m_act[i] = 2'd0; end
  endtask

  task automatic model_edge();
    logic pwm, has_top, at_top, bot;
    logic [W-1:0] top;
    logic [NCH-1:0] hit;
    pwm     = (m_mode == 3'd3) || (m_mode == 3'd7);
    has_top = pwm || (m_mode == 3'd2);
    top     = ((m_mode == 3'd2) || (m_mode == 3'd7)) ? m_ocr[0] : 8'hFF;
    at_top  = (m_cnt == top);
    bot     = tick && pwm && at_top;
    for (int i = 0; i < NCH; i++) begin
      hit[i] = tick && !m_blk && (m_cnt == m_ocr[i]);
      if (pwm) begin
        if (hit[i] && m_act[i] == 2'd2) m_wave[i] = 1'b0;
        if (hit[i] && m_act[i] == 2'd3) m_wave[i] = 1'b1;
        if (bot && m_act[i] == 2'd2) m_wave[i] = 1'b1;
        if (bot && m_act[i] == 2'd3) m_wave[i] = 1'b0;
      end else if (hit[i] || force_cmp[i]) begin
        if (m_act[i] == 2'd1) m_wave[i] = ~m_wave[i];
        if (m_act[i] == 2'd2) m_wave[i] = 1'b0;
        if (m_act[i] == 2'd3) m_wave[i] = 1'b1;
      end
      m_mf[i] = hit[i] | (m_mf[i] & ~flag_clr[i+1]);
    end
    m_ovf = (tick && (pwm ? at_top : (m_cnt == 8'hFF))) | (m_ovf & ~flag_clr[0]);
    if (cnt_wr) m_cnt = cnt_wdata;
    else if (tick) m_cnt = (has_top && at_top) ? 8'h00 : m_cnt + 8'd1;
    m_blk = cnt_wr ? 1'b1 : (tick ? 1'b0 : m_blk);
    for (int i = 0; i < NCH; i++) if (ocr_wr[i]) m_ocr[i] = ocr_wdata;
    if (ctl_wr) begin
      m_mode = ctl_mode;
      for (int i = 0; i < NCH; i++) m_act[i] = ctl_act[2*i +: 2];
    end
  endtask

  task automatic idle_inputs();
    tick = 1'b0; cnt_wr = 1'b0; cnt_wdata = '0; ocr_wr = '0; ocr_wdata = '0;
    ctl_wr = 1'b0; ctl_mode = 3'd0; ctl_act = '0; force_cmp = '0; flag_clr = '0;
  endtask

  // Inputs are set by the caller after a falling edge; one clock, then compare.
  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "count", int'(count), int'(m_cnt));
    chk(tag, "wave", int'(wave), int'(m_wave));
    chk(tag, "ovf_flag", int'(ovf_flag), int'(m_ovf));
    chk(tag, "match_flag", int'(match_flag), int'(m_mf));
    idle_inputs();
  endtask

  task automatic set_ctl(input logic [2:0] md, input logic [3:0] ac, input string tag);
    ctl_wr = 1'b1; ctl_mode = md; ctl_act = ac; cyc(tag);
  endtask

  task automatic set_ocr(input int ch, input logic [W-1:0] v, input string tag);
    ocr_wr[ch] = 1'b1; ocr_wdata = v; cyc(tag);
  endtask

  task automatic load_cnt(input logic [W-1:0] v, input string tag);
    cnt_wr = 1'b1; cnt_wdata = v; cyc(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int k = 0; k < n; k++) begin tick = 1'b1; cyc(tag); end
  endtask

  initial begin
    #(TCLK * 190000);
    bad++;
    $display("FAIL watchdog: got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [2:0] modes [5];
    logic [W-1:0] oa [3];
    logic [W-1:0] ob [3];
    modes[0] = 3'd0; modes[1] = 3'd2; modes[2] = 3'd3; modes[3] = 3'd7; modes[4] = 3'd5;
    oa[0] = 8'd0; oa[1] = 8'd9;  oa[2] = 8'd200;
    ob[0] = 8'd0; ob[1] = 8'd9;  ob[2] = 8'd4;
    idle_inputs();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc("R1");

    // R2 free-running wrap and hold
    load_cnt(8'hFD, "R9");
    ticks(4, "R2");
    cyc("R2");
    flag_clr = 3'b001; cyc("R10");

    // R3 clear-on-match, register A = 0, toggle -> period of two ticks
    set_ctl(3'd2, 4'b0101, "R11");
    load_cnt(8'd0, "R9");
    ticks(6, "R3");
    set_ocr(0, 8'd3, "R11");
    ticks(9, "R3");

    // R4 / R5 PWM with TOP = register A, channel B compare equal to TOP
    set_ocr(1, 8'd3, "R11");
    set_ctl(3'd7, 4'b1110, "R4");
    ticks(10, "R5");
    set_ocr(1, 8'd1, "R11");
    ticks(10, "R5");
    force_cmp = 2'b11; cyc("R8");
    set_ctl(3'd3, 4'b1011, "R4");
    load_cnt(8'hFC, "R9");
    ticks(6, "R4");

    // R6 / R8 non-PWM actions and force
    set_ctl(3'd0, 4'b0001, "R6");
    force_cmp = 2'b11; cyc("R8");
    force_cmp = 2'b01; cyc("R8");
    set_ocr(0, 8'd10, "R11");
    load_cnt(8'd9, "R9");
    tick = 1'b1; cyc("R7");
    tick = 1'b1; force_cmp = 2'b01; cyc("R8");
    set_ctl(3'd0, 4'b1011, "R6");
    load_cnt(8'd10, "R9");
    tick = 1'b1; cyc("R9");
    load_cnt(8'd10, "R9");
    tick = 1'b1; cnt_wr = 1'b1; cnt_wdata = 8'd10; cyc("R9");
    tick = 1'b1; cyc("R9");
    load_cnt(8'd10, "R9");
    cyc("R9");
    tick = 1'b1; cyc("R9");
    load_cnt(8'd10, "R9");
    tick = 1'b1; cyc("R7");
    load_cnt(8'd10, "R9");
    cyc("R7");
    tick = 1'b1; flag_clr = 3'b010; cyc("R10");
    flag_clr = 3'b110; cyc("R10");

    // Sweeps over modes, action pairs and compare values
    for (int mi = 0; mi < 5; mi++)
      for (int ac = 0; ac < 16; ac++)
        for (int oi = 0; oi < 3; oi++) begin
          set_ocr(0, oa[oi], "R11");
          set_ocr(1, ob[oi], "R11");
          set_ctl(modes[mi], ac[3:0], "R11");
          for (int c = 0; c < 300; c++) begin
            tick = ($urandom_range(7) != 0);
            if ($urandom_range(31) == 0) begin
              cnt_wr = 1'b1; cnt_wdata = W'($urandom_range(255));
            end
            force_cmp = ($urandom_range(15) == 0) ? NCH'($urandom_range(3)) : '0;
            flag_clr  = ($urandom_range(7) == 0) ? (NCH+1)'($urandom_range(7)) : '0;
            if (modes[mi] == 3'd3 || modes[mi] == 3'd7) cyc("R5");
            else cyc("R6");
          end
        end

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule